// File: doc/BRIEF.md
# PCI Central Bus Arbiter with Bypass

This block decides which master owns a shared PCI-style bus. It serves five external masters, each with an active-low request input and an active-low grant output, and one internal requester that stands for the host device's own master. Grants are awarded per access. The next owner is chosen while the current transfer is still on the bus, so changing owner costs no bus cycles unless the bus is idle. When no master is asking for the bus, the grant is parked on the internal requester.

Arbitration can be switched off in two ways. A strap is sampled as reset is released: low turns the arbiter on and high turns it off. After that, a control bit takes over, and its sense is the opposite of the strap: 1 means on. While the arbiter is off, pair 0 is used in reverse. The grant-0 pin carries the host's own request out to an external arbiter, and the request-0 pin brings that arbiter's grant back in. The arbiter behaves the same whether the device is the system host or an agent.

Top module: `pci_central_arb`

## Requirements
- R1: At the last clock edge with `rst_n` low, the enable bit loads the inverse of `strap_dis`, and `arb_on` shows the result. With the strap low, the block leaves reset with only `host_gnt` asserted. With the strap high, it leaves reset in bypass mode.
- R2: A clock edge with `cfg_wr` high loads `cfg_en` into the enable bit (1 = on, 0 = off). After a write that turns the arbiter on, the cycle that follows has no grant asserted. Arbitration resumes at the next edge.
- R3: While `arb_on` is 0, `mgnt_n[0]` equals the inverse of `host_req` and `host_gnt` equals the inverse of `mreq_n[0]`. Both follow their inputs without a clock. `mgnt_n[4:1]` stay high, and requests on `mreq_n[4:1]` have no effect on any output.
- R4: While the arbiter is on, at most one of {`host_gnt`, inverted `mgnt_n[4:0]`} is asserted in any cycle.
- R5: While the arbiter is on and no master requests for two edges in a row, `host_gnt` is asserted. Requester index 5 is the internal requester.
- R6: Requesters are numbered 0 to 4 for the external masters and 5 for the host. The winner is the first active request in the order that starts one index past the current owner and wraps from 5 to 0.
- R7: If the owner changes while the bus is idle (`bus_frame_n` and `bus_irdy_n` both high), the old grant is removed first. One cycle with no grant follows, and the new grant appears the cycle after that.
- R8: If the owner changes while the bus is busy, the new grant appears in the cycle right after the old one. No cycle without a grant comes between them.
- R9: A granted master that keeps requesting and has not yet driven `bus_frame_n` low keeps its grant, even when other masters are requesting.
- R10: Once the granted master drives `bus_frame_n` low, its access has started. The grant then moves to the next winner in rotation, even if that master is still requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_dis | input | 1 | Enable strap, sampled as reset is released; high turns the arbiter off |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | Value written to the enable bit; 1 = on |
| mreq_n | input | 5 | Active-low requests from the external masters; in bypass, bit 0 is the external grant |
| mgnt_n | output | 5 | Active-low grants to the external masters; in bypass, bit 0 carries the host's request |
| host_req | input | 1 | Request from the internal master, active high |
| host_gnt | output | 1 | Grant to the internal master, active high |
| bus_frame_n | input | 1 | Bus frame signal, active low |
| bus_irdy_n | input | 1 | Bus initiator-ready signal, active low |
| arb_on | output | 1 | Current state of the enable bit |

## Verification
Two functions can fall in the same cycle. The owner drives FRAME low to start its access, and in that same cycle the grant is taken from it for the next winner. The bench provokes this by pulling FRAME low while a second master is already waiting. It then expects the new grant at the very next edge with no empty cycle, and it expects the rotation to skip the owner even when the owner keeps its request asserted. The same pattern, repeated with the bus idle, must instead show exactly one cycle with no grant.

// File: rtl/pca_pkg.sv
package pca_pkg;

   // Action taken on the grant state at the next clock edge.
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,  // keep the current owner
      ACT_TAKE = 2'd1,  // no grant out: hand it to the target
      ACT_SWAP = 2'd2,  // bus busy: move straight to the target
      ACT_DROP = 2'd3   // bus idle: remove the grant, leaving a gap
   } arb_act_e;

endpackage

// File: rtl/pca_rr_pick.sv
module pca_rr_pick #(
   parameter int N  = 6,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic [IW-1:0] win,
   output logic          any
);

   // Search one past the last owner, wrap around, and stop at the first request.
   always_comb begin
      win = '0;
      any = 1'b0;
      for (int i = 1; i <= N; i++) begin
         int k;
         k = int'(last) + i;
         if (k >= N) k = k - N;
         if (!any && req[k]) begin
            any = 1'b1;
            win = IW'(k);
         end
      end
   end

endmodule

// File: rtl/pca_enable.sv
module pca_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_dis,
   input  logic cfg_wr,
   input  logic cfg_en,
   output logic en
);

   // The strap is inverted into the bit during reset; after reset, writes decide.
   always_ff @(posedge clk) begin
      if (!rst_n)      en <= ~strap_dis;
      else if (cfg_wr) en <= cfg_en;
   end

endmodule

// File: rtl/pca_gnt_drv.sv
module pca_gnt_drv #(
   parameter int N_EXT = 5,
   parameter int IW    = 3
) (
   input  logic             en,
   input  logic             gnt_on,
   input  logic [IW-1:0]    owner,
   input  logic             host_req,
   input  logic             ext_gnt_n,
   output logic [N_EXT-1:0] mgnt_n,
   output logic             host_gnt
);

   localparam logic [IW-1:0] HOST_IDX = IW'(N_EXT);

   for (genvar g = 0; g < N_EXT; g++) begin : g_pin
      if (g == 0) begin : g_shared
         // Pair 0 reverses direction in bypass: it carries the host's request out.
         assign mgnt_n[g] = en ? ~(gnt_on && (owner == IW'(g))) : ~host_req;
      end else begin : g_plain
         assign mgnt_n[g] = ~(en && gnt_on && (owner == IW'(g)));
      end
   end

   assign host_gnt = en ? (gnt_on && (owner == HOST_IDX)) : ~ext_gnt_n;

endmodule

// File: rtl/pci_central_arb.sv
module pci_central_arb #(
   parameter int N_EXT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_dis,
   input  logic             cfg_wr,
   input  logic             cfg_en,
   input  logic [N_EXT-1:0] mreq_n,
   output logic [N_EXT-1:0] mgnt_n,
   input  logic             host_req,
   output logic             host_gnt,
   input  logic             bus_frame_n,
   input  logic             bus_irdy_n,
   output logic             arb_on
);
   import pca_pkg::*;

   localparam int N_ALL = N_EXT + 1;
   localparam int IW    = $clog2(N_ALL);
   localparam logic [IW-1:0] HOST_IDX = IW'(N_EXT);

   if (N_EXT < 2 || N_EXT > 15) begin : g_bad_count
      $error("pci_central_arb: N_EXT must lie in 2..15");
   end

   logic             en;
   logic [N_ALL-1:0] req_v;
   logic [IW-1:0]    owner_q, win, target;
   logic             gnt_on_q, started_q, any_req;
   logic             busy, used, rearb;
   arb_act_e         act;

   assign req_v = {host_req, ~mreq_n};
   assign busy  = ~bus_frame_n | ~bus_irdy_n;
   // The access counts as started once FRAME goes low under the grant.
   assign used  = started_q | (gnt_on_q & ~bus_frame_n);
   assign rearb = ~gnt_on_q | ~req_v[owner_q] | used;

   pca_enable u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_dis (strap_dis),
      .cfg_wr    (cfg_wr),
      .cfg_en    (cfg_en),
      .en        (en)
   );

   pca_rr_pick #(.N(N_ALL), .IW(IW)) u_pick (
      .req  (req_v),
      .last (owner_q),
      .win  (win),
      .any  (any_req)
   );

   // With no requests, the target is the park position (the internal requester).
   assign target = any_req ? win : HOST_IDX;

   always_comb begin
      act = ACT_HOLD;
      if (rearb) begin
         if (!gnt_on_q)              act = ACT_TAKE;
         else if (target != owner_q) act = busy ? ACT_SWAP : ACT_DROP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q   <= HOST_IDX;
         gnt_on_q  <= ~strap_dis;
         started_q <= 1'b0;
      end else if (!en) begin
         owner_q   <= HOST_IDX;
         gnt_on_q  <= 1'b0;
         started_q <= 1'b0;
      end else begin
         unique case (act)
            ACT_TAKE, ACT_SWAP: begin
               owner_q   <= target;
               gnt_on_q  <= 1'b1;
               started_q <= 1'b0;
            end
            ACT_DROP: begin
               gnt_on_q  <= 1'b0;
               started_q <= 1'b0;
            end
            default: begin
               // The same owner wins again: once the bus goes idle, it may start a new access.
               if (rearb && used && !busy)        started_q <= 1'b0;
               else if (gnt_on_q && !bus_frame_n) started_q <= 1'b1;
            end
         endcase
      end
   end

   pca_gnt_drv #(.N_EXT(N_EXT), .IW(IW)) u_drv (
      .en        (en),
      .gnt_on    (gnt_on_q),
      .owner     (owner_q),
      .host_req  (host_req),
      .ext_gnt_n (mreq_n[0]),
      .mgnt_n    (mgnt_n),
      .host_gnt  (host_gnt)
   );

   assign arb_on = en;

endmodule

// File: rtl/pci_central_arb_chk.sv
module pci_central_arb_chk #(
   parameter int N_EXT = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             strap_dis,
   input logic             cfg_wr,
   input logic             cfg_en,
   input logic [N_EXT-1:0] mreq_n,
   input logic [N_EXT-1:0] mgnt_n,
   input logic             host_req,
   input logic             host_gnt,
   input logic             bus_frame_n,
   input logic             bus_irdy_n,
   input logic             arb_on
);

   logic [N_EXT:0] gvec;
   logic           busy, idle_req, any_g;

   assign gvec     = {host_gnt, ~mgnt_n};
   assign busy     = ~bus_frame_n | ~bus_irdy_n;
   assign idle_req = (&mreq_n) & ~host_req;
   assign any_g    = |gvec;

   p_strap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (arb_on == !$past(strap_dis)));

   p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_wr)) |-> (arb_on == $past(cfg_en)));

   p_bypass_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_on |-> (&mgnt_n[N_EXT-1:1]));

   p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arb_on |-> $onehot0(gvec));

   p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_on && $past(rst_n) && $past(rst_n, 2) && $past(arb_on) && $past(arb_on, 2)
       && $past(idle_req) && $past(idle_req, 2)) |-> host_gnt);

   p_idle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(arb_on) && arb_on && $past(any_g) && any_g
       && ($past(gvec) != gvec)) |-> $past(busy));

   p_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(arb_on) && arb_on && $past(any_g) && $past(busy)) |-> any_g);

endmodule

bind pci_central_arb pci_central_arb_chk #(.N_EXT(N_EXT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .strap_dis   (strap_dis),
   .cfg_wr      (cfg_wr),
   .cfg_en      (cfg_en),
   .mreq_n      (mreq_n),
   .mgnt_n      (mgnt_n),
   .host_req    (host_req),
   .host_gnt    (host_gnt),
   .bus_frame_n (bus_frame_n),
   .bus_irdy_n  (bus_irdy_n),
   .arb_on      (arb_on)
);

// File: tb/pci_central_arb_test.sv
module pci_central_arb_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_dis = 1'b0;
   logic       cfg_wr = 1'b0;
   logic       cfg_en = 1'b0;
   logic [4:0] mreq_n = 5'b11111;
   logic [4:0] mgnt_n;
   logic       host_req = 1'b0;
   logic       host_gnt;
   logic       bus_frame_n = 1'b1;
   logic       bus_irdy_n = 1'b1;
   logic       arb_on;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   typedef struct {
      int         at;
      logic [4:0] g;
      logic       h;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pci_central_arb #(.N_EXT(5)) uut (
      .clk(clk), .rst_n(rst_n), .strap_dis(strap_dis), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
      .mreq_n(mreq_n), .mgnt_n(mgnt_n), .host_req(host_req), .host_gnt(host_gnt),
      .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n), .arb_on(arb_on)
   );

   // Monitor: one time unit after each edge, compare the outputs with the entry queued for this cycle.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc || mgnt_n !== e.g || host_gnt !== e.h) begin
               errors++;
               $display("FAIL %s cycle %0d: gnt_n=%b host_gnt=%b, expected gnt_n=%b host_gnt=%b",
                        e.tag, cyc, mgnt_n, host_gnt, e.g, e.h);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // Queue the raw outputs expected after the next edge, then advance one cycle.
   task automatic exp_raw(input logic [4:0] g, input logic h, input string tag);
      exp_t e;
      e.at = cyc + 1; e.g = g; e.h = h; e.tag = tag;
      sb.push_back(e);
      tick();
   endtask

   // own: -1 = no grant, 0..4 = external master, 5 = internal requester.
   task automatic exp_own(input int own, input string tag);
      logic [4:0] g;
      g = 5'b11111;
      if (own >= 0 && own < 5) g[own] = 1'b0;
      exp_raw(g, (own == 5), tag);
   endtask

   task automatic chk_on(input logic exp, input string tag);
      checks++;
      if (arb_on !== exp) begin
         errors++;
         $display("FAIL %s: arb_on=%b expected %b", tag, arb_on, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      chk_on(1'b1, "R1 strap low enables");
      exp_own(5, "R1 reset park");
      exp_own(5, "R5 park idle");

      // External master 2 asks on an idle bus: one empty cycle comes first.
      mreq_n[2] = 1'b0;
      exp_own(-1, "R7 idle gap");
      exp_own(2, "R7 new grant");
      mreq_n[4] = 1'b0;
      exp_own(2, "R9 hold before frame");
      exp_own(2, "R9 hold before frame");

      // 2 starts and drops its request; 4 wins directly while the bus is busy.
      bus_frame_n = 1'b0; mreq_n[2] = 1'b1;
      exp_own(4, "R8 hidden switch");
      bus_frame_n = 1'b1; mreq_n[1] = 1'b0; host_req = 1'b1;
      exp_own(4, "R9 hold not started");
      // 4 starts: the order after 4 puts the host (5) ahead of master 1.
      bus_frame_n = 1'b0; mreq_n[4] = 1'b1;
      exp_own(5, "R6 rotation to host");
      bus_frame_n = 1'b1;
      exp_own(5, "R9 host holds");
      bus_frame_n = 1'b0; host_req = 1'b0;
      exp_own(1, "R6 wrap to master 1");
      bus_frame_n = 1'b1; mreq_n[1] = 1'b1;
      exp_own(-1, "R7 gap on release");
      exp_own(5, "R5 park after release");
      exp_own(5, "R5 park steady");

      // Masters 0 and 3 keep requesting; each start passes the grant on.
      mreq_n[0] = 1'b0; mreq_n[3] = 1'b0;
      exp_own(-1, "R7 gap before 0");
      exp_own(0, "R6 from host wraps to 0");
      bus_frame_n = 1'b0;
      exp_own(3, "R10 started owner loses");
      bus_frame_n = 1'b1;
      exp_own(3, "R9 hold 3");
      bus_frame_n = 1'b0;
      exp_own(0, "R10 back to 0");
      bus_frame_n = 1'b1; mreq_n[0] = 1'b1; mreq_n[3] = 1'b1;
      exp_own(-1, "R7 gap before park");
      exp_own(5, "R5 park");

      // Turn the arbiter off through the register: pair 0 reverses direction.
      cfg_wr = 1'b1; cfg_en = 1'b0; host_req = 1'b1; mreq_n[0] = 1'b0;
      exp_raw(5'b11110, 1'b1, "R3 bypass forwards");
      chk_on(1'b0, "R2 write 0 disables");
      cfg_wr = 1'b0; host_req = 1'b0; mreq_n[0] = 1'b1; mreq_n[3] = 1'b0; mreq_n[2] = 1'b0;
      exp_raw(5'b11111, 1'b0, "R3 other requests ignored");
      exp_raw(5'b11111, 1'b0, "R3 other requests ignored");

      // Turn it back on with master 3 still requesting.
      mreq_n[2] = 1'b1;
      cfg_wr = 1'b1; cfg_en = 1'b1;
      exp_own(-1, "R2 empty cycle after enable");
      chk_on(1'b1, "R2 write 1 enables");
      cfg_wr = 1'b0;
      exp_own(3, "R2 arbitration resumes");
      mreq_n[3] = 1'b1;
      exp_own(-1, "R7 gap");
      exp_own(5, "R5 park");

      // Reset again with the strap high: the block comes up in bypass.
      rst_n = 1'b0; strap_dis = 1'b1;
      tick(); tick();
      rst_n = 1'b1;
      exp_raw(5'b11111, 1'b0, "R1 strap high bypass");
      chk_on(1'b0, "R1 strap high disables");
      host_req = 1'b1;
      exp_raw(5'b11110, 1'b0, "R3 host request out");
      host_req = 1'b0; mreq_n[0] = 1'b0;
      exp_raw(5'b11111, 1'b1, "R3 external grant in");
      mreq_n[0] = 1'b1;
      tick(); tick();
      finish_run();
   end

endmodule